// File: doc/BRIEF.md
# Configurable On-Chip RAM Port

A single-clock on-chip word memory with one access port, shaped at build time. Word width, depth and power-up contents are parameters. The port always takes an address and returns read data. Parameters select the other features:

- whether the port can write;
- how finely a write can be split into lanes;
- whether the read data is registered or follows the address at once;
- whether a read-enable gates the registered output;
- what the registered output shows in a cycle that also writes.

A write lands at the clock edge. It stores the merged word: the new data in the enabled lanes and the old data in all other lanes. The registered read stage then picks, according to the selected mode, one of three values: the merged word, the word as it stood before the write, or nothing new. In combinational mode the read-enable and the mode setting have no effect. The output shows the array word at the current address.

Top module: `ram_port`

## Requirements
- R1: With `WRITABLE`=1 and any `wr_en_i` bit high, the addressed word is updated at the clock edge. A later read of that address returns the stored value.
- R2: With `WR_GRAN` nonzero, `wr_en_i` has `WORD_W/WR_GRAN` bits. Bit k writes data bits [k*WR_GRAN +: WR_GRAN] and leaves the other bits of the word unchanged. With `WR_GRAN`=0, `wr_en_i` is one bit that writes the whole word.
- R3: With `COMB_READ`=0 and a read enabled, `rdata_o` shows the word at `addr_i` one clock after the address is presented.
- R4: With `COMB_READ`=0 and `HAS_RD_EN`=1, `rd_en_i` low keeps `rdata_o` unchanged through the next edge. This applies even in a write cycle, and the write itself still takes place.
- R5: With `COMB_READ`=1, `rdata_o` equals the current array word at `addr_i` in the same cycle. `rd_en_i` and `RDW_MODE` have no effect in this mode.
- R6: In write-first mode (`RDW_MODE`=0, the default), an enabled read in a write cycle returns the merged word. The merged word holds the new lanes and the old data in the lanes that are not enabled.
- R7: In read-first mode (`RDW_MODE`=1), an enabled read in a write cycle returns the word as it was before the write.
- R8: In no-change mode (`RDW_MODE`=2), `rdata_o` holds its previous value through any write cycle.
- R9: Word i starts as `INIT[i*WORD_W +: WORD_W]`, and the default is all zeros. Reset clears the registered `rdata_o` to zero and leaves the array contents untouched.
- R10: A second write to the same address in the very next cycle merges with the result of the first write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset of the read register |
| addr_i | input | $clog2(DEPTH) | Word address |
| wr_en_i | input | WORD_W/WR_GRAN, or 1 when WR_GRAN=0 | Lane write enables; ignored when WRITABLE=0 |
| wdata_i | input | WORD_W | Write data |
| rd_en_i | input | 1 | Read enable for the registered output |
| rdata_o | output | WORD_W | Read data |

## Verification
Four instances run side by side on the same stimulus: write-first, read-first and no-change with registered reads, and one combinational-read port. Each is compared against a behavioural array model.

The stimulus contains plain reads, full-word writes, single-lane and two-lane writes, back-to-back writes to one address, and writes with the read-enable low. A write cycle separates the three modes: the modes agree on plain reads and differ only when a read meets a write. Partial writes show whether non-enabled lanes are kept. Reading untouched addresses after reset confirms the initial contents. A mid-run reset shows that the array survives while the output clears.

// File: rtl/ram_port_pkg.sv
`timescale 1ns/1ps
package ram_port_pkg;
  typedef enum logic [1:0] {
    RDW_WRITE_FIRST = 2'd0,
    RDW_READ_FIRST  = 2'd1,
    RDW_NO_CHANGE   = 2'd2
  } rdw_mode_e;

  function automatic int lane_width(int word_w, int gran);
    return (gran == 0) ? word_w : gran;
  endfunction
endpackage

// File: rtl/ram_lane_merge.sv
`timescale 1ns/1ps
module ram_lane_merge #(
  parameter int WORD_W = 32,
  parameter int LANE_W = 8,
  localparam int NLANE = WORD_W / LANE_W
) (
  input  logic [WORD_W-1:0] old_i,
  input  logic [WORD_W-1:0] wdata_i,
  input  logic [NLANE-1:0]  lane_en_i,
  output logic [WORD_W-1:0] merged_o
);
  for (genvar k = 0; k < NLANE; k++) begin : g_lane
    assign merged_o[k*LANE_W +: LANE_W] = lane_en_i[k] ? wdata_i[k*LANE_W +: LANE_W]
                                                      : old_i[k*LANE_W +: LANE_W];
  end
endmodule

// File: rtl/ram_store.sv
`timescale 1ns/1ps
module ram_store #(
  parameter int WORD_W = 32,
  parameter int DEPTH  = 16,
  parameter logic [DEPTH*WORD_W-1:0] INIT = '0,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [AW-1:0]     addr_i,
  input  logic [WORD_W-1:0] wword_i,
  output logic [WORD_W-1:0] rword_o
);
  logic [WORD_W-1:0] mem [DEPTH];

  // power-up contents only; reset leaves the array alone
  initial begin
    for (int i = 0; i < DEPTH; i++) mem[i] = INIT[i*WORD_W +: WORD_W];
  end

  always_ff @(posedge clk_i) begin
    if (wr_i) mem[addr_i] <= wword_i;
  end

  assign rword_o = mem[addr_i];

  a_r1_word_stored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> mem[$past(addr_i)] == $past(wword_i));
endmodule

// File: rtl/ram_rd_stage.sv
`timescale 1ns/1ps
module ram_rd_stage
  import ram_port_pkg::*;
#(
  parameter int        WORD_W    = 32,
  parameter bit        COMB_READ = 1'b0,
  parameter bit        HAS_RD_EN = 1'b1,
  parameter rdw_mode_e RDW_MODE  = RDW_WRITE_FIRST
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rd_en_i,
  input  logic              wr_i,
  input  logic [WORD_W-1:0] old_i,
  input  logic [WORD_W-1:0] merged_i,
  output logic [WORD_W-1:0] rdata_o
);
  if (COMB_READ) begin : g_comb
    assign rdata_o = old_i;
  end else begin : g_reg
    logic              rd_ok;
    logic              upd;
    logic [WORD_W-1:0] nxt;
    logic [WORD_W-1:0] q;

    assign rd_ok = HAS_RD_EN ? rd_en_i : 1'b1;

    always_comb begin
      upd = rd_ok;
      nxt = old_i;
      unique case (RDW_MODE)
        RDW_WRITE_FIRST: if (wr_i) nxt = merged_i;
        RDW_READ_FIRST:  nxt = old_i;
        RDW_NO_CHANGE:   if (wr_i) upd = 1'b0;
        default:         nxt = old_i;
      endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)  q <= '0;
      else if (upd) q <= nxt;
    end

    assign rdata_o = q;

    if (HAS_RD_EN) begin : g_rd_en_chk
      a_r4_rd_en_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !rd_en_i |=> $stable(rdata_o));
    end

    if (RDW_MODE == RDW_NO_CHANGE) begin : g_nc_chk
      a_r8_no_change: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wr_i |=> $stable(rdata_o));
    end
  end
endmodule

// File: rtl/ram_port.sv
`timescale 1ns/1ps
module ram_port
  import ram_port_pkg::*;
#(
  parameter int        WORD_W    = 32,
  parameter int        DEPTH     = 16,
  parameter int        WR_GRAN   = 8,
  parameter bit        WRITABLE  = 1'b1,
  parameter bit        COMB_READ = 1'b0,
  parameter bit        HAS_RD_EN = 1'b1,
  parameter rdw_mode_e RDW_MODE  = RDW_WRITE_FIRST,
  parameter logic [DEPTH*WORD_W-1:0] INIT = '0,
  localparam int AW     = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int LANE_W = lane_width(WORD_W, WR_GRAN),
  localparam int WE_W   = WORD_W / LANE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [AW-1:0]     addr_i,
  input  logic [WE_W-1:0]   wr_en_i,
  input  logic [WORD_W-1:0] wdata_i,
  input  logic              rd_en_i,
  output logic [WORD_W-1:0] rdata_o
);
  logic [WE_W-1:0]   lane_en;
  logic              wr;
  logic [WORD_W-1:0] old_word;
  logic [WORD_W-1:0] merged;

  assign lane_en = WRITABLE ? wr_en_i : '0;
  assign wr      = |lane_en;

  ram_lane_merge #(.WORD_W(WORD_W), .LANE_W(LANE_W)) u_merge (
    .old_i     (old_word),
    .wdata_i   (wdata_i),
    .lane_en_i (lane_en),
    .merged_o  (merged)
  );

  ram_store #(.WORD_W(WORD_W), .DEPTH(DEPTH), .INIT(INIT)) u_store (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (wr),
    .addr_i  (addr_i),
    .wword_i (merged),
    .rword_o (old_word)
  );

  ram_rd_stage #(
    .WORD_W(WORD_W), .COMB_READ(COMB_READ), .HAS_RD_EN(HAS_RD_EN), .RDW_MODE(RDW_MODE)
  ) u_rd (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .rd_en_i  (rd_en_i),
    .wr_i     (wr),
    .old_i    (old_word),
    .merged_i (merged),
    .rdata_o  (rdata_o)
  );

  if (!COMB_READ) begin : g_reg_chk
    logic rd_ok;
    assign rd_ok = HAS_RD_EN ? rd_en_i : 1'b1;

    if (WRITABLE && RDW_MODE == RDW_WRITE_FIRST) begin : g_wf
      a_r6_write_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rd_ok && (&wr_en_i)) |=> rdata_o == $past(wdata_i));
    end
    if (RDW_MODE == RDW_READ_FIRST) begin : g_rf
      a_r7_read_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rd_ok && wr) |=> rdata_o == $past(old_word));
    end
  end else begin : g_comb_chk
    a_r5_comb_after_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wr |=> (addr_i != $past(addr_i)) || (rdata_o == $past(merged)));
  end
endmodule

// File: tb/tb_ram_port.sv
`timescale 1ns/1ps
module tb_ram_port;
  import ram_port_pkg::*;

  localparam int W = 32;
  localparam int D = 16;
  localparam int G = 8;
  localparam int AW = 4;
  localparam int WE = W / G;

  function automatic logic [D*W-1:0] mk_init();
    logic [D*W-1:0] v;
    for (int i = 0; i < D; i++) v[i*W +: W] = 32'h5A00_0000 | (i * 32'h0101);
    return v;
  endfunction
  localparam logic [D*W-1:0] INIT_V = mk_init();

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [WE-1:0] we = '0;
  logic [W-1:0]  wd = '0;
  logic          re = 1'b0;
  logic [W-1:0]  q_wf, q_rf, q_nc, q_cb;

  always #4 clk = ~clk;  // 125 MHz

  ram_port #(.WORD_W(W), .DEPTH(D), .WR_GRAN(G), .INIT(INIT_V)) dut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wr_en_i(we), .wdata_i(wd),
    .rd_en_i(re), .rdata_o(q_wf));
  ram_port #(.WORD_W(W), .DEPTH(D), .WR_GRAN(G), .INIT(INIT_V),
             .RDW_MODE(RDW_READ_FIRST)) dut_rf (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wr_en_i(we), .wdata_i(wd),
    .rd_en_i(re), .rdata_o(q_rf));
  ram_port #(.WORD_W(W), .DEPTH(D), .WR_GRAN(G), .INIT(INIT_V),
             .RDW_MODE(RDW_NO_CHANGE)) dut_nc (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wr_en_i(we), .wdata_i(wd),
    .rd_en_i(re), .rdata_o(q_nc));
  // mode setting must be ignored here (R5)
  ram_port #(.WORD_W(W), .DEPTH(D), .WR_GRAN(G), .INIT(INIT_V), .COMB_READ(1'b1),
             .RDW_MODE(RDW_NO_CHANGE)) dut_cb (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wr_en_i(we), .wdata_i(wd),
    .rd_en_i(re), .rdata_o(q_cb));

  int checks = 0;
  int errors = 0;
  logic [W-1:0] model [D];
  logic [W-1:0] e_wf, e_rf, e_nc;

  task automatic chk(string tag, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(logic [AW-1:0] a, logic [WE-1:0] w, logic [W-1:0] d, logic r,
                      string tag);
    logic [W-1:0] old, mrg;
    @(negedge clk);
    addr = a; we = w; wd = d; re = r;
    #1;
    old = model[a];
    chk({tag, " R5 comb read"}, q_cb, old);
    for (int k = 0; k < WE; k++) mrg[k*G +: G] = w[k] ? d[k*G +: G] : old[k*G +: G];
    if (r) begin
      e_wf = (w != 0) ? mrg : old;
      e_rf = old;
      if (w == 0) e_nc = old;
    end
    if (w != 0) model[a] = mrg;
    @(posedge clk);
    #1;
    chk({tag, (w != 0) ? " R6 write-first" : (r ? " R3 read" : " R4 hold")}, q_wf, e_wf);
    chk({tag, (w != 0) ? " R7 read-first"  : (r ? " R3 read" : " R4 hold")}, q_rf, e_rf);
    chk({tag, (w != 0) ? " R8 no-change"   : (r ? " R3 read" : " R4 hold")}, q_nc, e_nc);
  endtask

  typedef struct packed {
    logic [AW-1:0] a;
    logic [WE-1:0] w;
    logic [W-1:0]  d;
    logic          r;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t VEC [NV] = '{
    '{4'h1, 4'hF, 32'h1111_1111, 1'b1},  // R1 full write
    '{4'h1, 4'h0, 32'h0,         1'b1},  // R3 plain read
    '{4'h1, 4'h3, 32'hAAAA_BBBB, 1'b1},  // R2 low two lanes
    '{4'h1, 4'hC, 32'hCCCC_DDDD, 1'b1},  // R10 back-to-back same address
    '{4'h1, 4'h0, 32'h0,         1'b1},
    '{4'h2, 4'h0, 32'h0,         1'b0},  // R4 read disabled
    '{4'h2, 4'hF, 32'h2222_2222, 1'b0},  // R4 write with read disabled
    '{4'h2, 4'h0, 32'h0,         1'b1},
    '{4'h5, 4'h4, 32'h00EE_0000, 1'b1},  // R2 single lane
    '{4'h5, 4'h0, 32'h0,         1'b1},
    '{4'hF, 4'hF, 32'hFFFF_0000, 1'b1},
    '{4'h0, 4'h0, 32'h0,         1'b1},
    '{4'hF, 4'h1, 32'h0000_00AB, 1'b1},
    '{4'hF, 4'h8, 32'h9900_0000, 1'b1},  // R10
    '{4'hF, 4'h0, 32'h0,         1'b1},
    '{4'h7, 4'h0, 32'h0,         1'b1}
  };

  initial begin
    #1_600_000;
    errors++; checks++;
    $display("FAIL watchdog expired actual=%h expected=%h", 32'h0, 32'h1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < D; i++) model[i] = INIT_V[i*W +: W];
    e_wf = '0; e_rf = '0; e_nc = '0;
    repeat (3) @(negedge clk);
    chk("R9 reset value", q_wf, '0);
    chk("R9 reset value", q_rf, '0);
    chk("R9 reset value", q_nc, '0);
    rst_n = 1'b1;
    step(4'h3, 4'h0, '0, 1'b1, "R9 init word");
    step(4'hA, 4'h0, '0, 1'b1, "R9 init word");

    for (int i = 0; i < NV; i++) step(VEC[i].a, VEC[i].w, VEC[i].d, VEC[i].r, "vec");

    // R2: lane check readback of a partially written word
    step(4'h9, 4'h2, 32'h0000_7700, 1'b1, "R2 lane1");
    step(4'h9, 4'h0, '0, 1'b1, "R2 readback");
    chk("R2 merged word", q_wf, 32'h5A00_7709);

    // R10 directed: three writes to one address in a row
    step(4'h4, 4'h1, 32'h0000_0011, 1'b1, "R10 a");
    step(4'h4, 4'h2, 32'h0000_2200, 1'b1, "R10 b");
    step(4'h4, 4'h4, 32'h0033_0000, 1'b1, "R10 c");
    chk("R10 merged", q_wf, 32'h5A33_2211);

    // R9: mid-run reset clears output, keeps array
    @(negedge clk);
    rst_n = 1'b0; we = '0; re = 1'b0;
    #1;
    chk("R9 reset clears", q_wf, '0);
    chk("R9 reset clears", q_rf, '0);
    chk("R9 reset clears", q_nc, '0);
    e_wf = '0; e_rf = '0; e_nc = '0;
    @(negedge clk);
    rst_n = 1'b1;
    step(4'h1, 4'h0, '0, 1'b1, "R9 array kept");
    step(4'h4, 4'h0, '0, 1'b1, "R9 array kept");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule